// File: doc/BRIEF.md
# Byte-Laned Asynchronous Memory Control Decoder

This block is the device-side control logic of a 16-bit asynchronous memory, rebuilt as synchronous logic. Each rising clock edge samples two chip selects of opposite polarity, an output enable, a write enable and two active-low byte-lane enables. From these it decides whether the device is selected, whether the cycle reads or writes, and which byte lanes take part. The results are per-lane output-drive enables, per-lane write strobes and the read word. The cell array is a small byte-laned memory inside the block. Its depth is set by a parameter: the full device has a 20-bit word address, and the default here is 8 bits so that elaboration stays small.

The data bus is split into an input word and an output word, because there is no internal tristate. The drive enables show which output lanes the pins would actually drive. Undriven lanes read as zero.

Two low-power indications come out as separate pins:
- **Standby** reports a deselected device, or one with both byte lanes off.
- **Auto power-down** reports a fully selected device whose address has stopped changing for a set number of clock edges.

Top module: `bytelane_mem_ctl`

## Requirements
- R1: The device counts as selected only when `cs_n` is 0 and `cs` is 1 at the same edge. An edge that is not selected yields `lane_drive` = 00 and `lane_strobe` = 00, and stores nothing in the array.
- R2: A selected edge with `oe_n` = 0 and `we_n` = 1 is a read. After it, `lane_drive[0]` = NOT `lb_n` and `lane_drive[1]` = NOT `ub_n`.
- R3: `rd_data[7:0]` carries bits 7:0 of the addressed word when `lane_drive[0]` is 1. `rd_data[15:8]` carries bits 15:8 when `lane_drive[1]` is 1. Any lane that is not driven reads as 0.
- R4: A selected edge with `we_n` = 0 is a write and yields `lane_drive` = 00, whatever `oe_n` is.
- R5: After a selected write edge, `lane_strobe[0]` = NOT `lb_n` and `lane_strobe[1]` = NOT `ub_n`.
- R6: A write stores `wr_data[7:0]` only when `lb_n` = 0, and `wr_data[15:8]` only when `ub_n` = 0. The other lane of the word keeps its contents.
- R7: After each edge, `standby` is 1 exactly when the device was not selected or both `lb_n` and `ub_n` were 1.
- R8: A stable edge is one where the device is selected, `lb_n` = `ub_n` = 0, and `addr` equals the address sampled at the previous edge. `pwr_down` becomes 1 after the IDLE_CYC-th consecutive stable edge (default 4) and stays 1 while stable edges continue.
- R9: `pwr_down` is 0 after any edge where the address differs from the previous edge, where the device is not selected, or where either byte enable is 1.
- R10: `standby` and `pwr_down` are never 1 together.
- R11: While `rst` is 1, the outputs settle to `lane_drive` = 00, `lane_strobe` = 00, `standby` = 1, `pwr_down` = 0 and `rd_data` = 0. No write reaches the array during reset.
- R12: A word written at one edge is returned by a read of the same address sampled at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Low byte lane enable, active low |
| ub_n | input | 1 | High byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Data lines as seen by the device on a write |
| rd_data | output | 16 | Read word, undriven lanes zero |
| lane_drive | output | 2 | Per-lane output-drive enable |
| lane_strobe | output | 2 | Per-lane write strobe |
| standby | output | 1 | Deselected or no lane enabled |
| pwr_down | output | 1 | Auto power-down on a stable address |

## Verification
Every output is registered, so the drive enables, strobes, read word and standby are due at the first rising edge after the inputs that cause them. `pwr_down` is due at the IDLE_CYC-th consecutive stable edge, and it falls at the very edge that breaks the run. The bench changes inputs only on falling edges. It compares every output against its own model at the next falling edge, which is exactly one rising edge later. The directed checks use the same cadence, counting stable edges explicitly in the power-down cases.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lane_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/blm_decode.sv
module blm_decode
  import blm_pkg::*;
(
  input  logic  cs_n,
  input  logic  cs,
  input  logic  oe_n,
  input  logic  we_n,
  input  lane_t lane_n,
  output logic  sel_all,
  output lane_t drive,
  output lane_t strobe,
  output logic  stby
);
  logic sel, writing, reading;

  always_comb begin
    sel     = !cs_n && cs;
    writing = sel && !we_n;
    reading = sel && !oe_n && we_n;   // write has priority over output enable
    drive   = reading ? ~lane_n : '0;
    strobe  = writing ? ~lane_n : '0;
    stby    = !sel || (&lane_n);
    sel_all = sel && !(|lane_n);
  end
endmodule

// File: rtl/blm_array.sv
module blm_array
  import blm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  lane_t             we,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  output word_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      rd_q <= cells[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/blm_idle_timer.sv
module blm_idle_timer #(
  parameter int ADDR_W   = 8,
  parameter int IDLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_all,
  input  logic [ADDR_W-1:0] addr,
  output logic              pwr_down
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW:0] LIMIT = (CW+1)'(IDLE_CYC);

  logic              prev_ok;
  logic [ADDR_W-1:0] prev_addr;
  logic [CW-1:0]     run_q;
  logic [CW:0]       run_inc;
  logic              stable;

  always_comb begin
    stable  = sel_all && prev_ok && (addr == prev_addr);
    run_inc = {1'b0, run_q} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok   <= 1'b0;
      prev_addr <= '0;
      run_q     <= '0;
      pwr_down  <= 1'b0;
    end else begin
      prev_ok   <= 1'b1;
      prev_addr <= addr;
      if (!stable)                run_q <= '0;
      else if (run_inc <= LIMIT)  run_q <= run_inc[CW-1:0];
      pwr_down  <= stable && (run_inc >= LIMIT);
    end
  end
endmodule

// File: rtl/bytelane_mem_ctl.sv
module bytelane_mem_ctl
  import blm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int IDLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic [1:0]        lane_drive,
  output logic [1:0]        lane_strobe,
  output logic              standby,
  output logic              pwr_down
);
  lane_t lane_n, drive_d, strobe_d, mem_we;
  logic  sel_all, stby_d;
  word_t rd_raw;

  assign lane_n = {ub_n, lb_n};
  assign mem_we = rst ? '0 : strobe_d;

  blm_decode u_dec (
    .cs_n   (cs_n),
    .cs     (cs),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .lane_n (lane_n),
    .sel_all(sel_all),
    .drive  (drive_d),
    .strobe (strobe_d),
    .stby   (stby_d)
  );

  blm_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (addr),
    .wdata(wr_data),
    .rdata(rd_raw)
  );

  blm_idle_timer #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .sel_all (sel_all),
    .addr    (addr),
    .pwr_down(pwr_down)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_drive  <= '0;
      lane_strobe <= '0;
      standby     <= 1'b1;
    end else begin
      lane_drive  <= drive_d;
      lane_strobe <= strobe_d;
      standby     <= stby_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rmask
    assign rd_data[g*LANE_W +: LANE_W] =
      lane_drive[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/bytelane_mem_ctl_chk.sv
module bytelane_mem_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              cs,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        lane_drive,
  input logic [1:0]        lane_strobe,
  input logic              standby,
  input logic              pwr_down
);
  logic sel;
  assign sel = !cs_n && cs;

  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (lane_drive == 2'b00 && lane_strobe == 2'b00));

  p_read_lanes_r2: assert property (@(posedge clk) disable iff (rst)
    (sel && !oe_n && we_n) |=> (lane_drive == ~$past({ub_n, lb_n})));

  p_write_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (sel && !we_n) |=> (lane_drive == 2'b00));

  p_strobe_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    (sel && !we_n) |=> (lane_strobe == ~$past({ub_n, lb_n})));

  p_standby_on_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel || (lb_n && ub_n)) |=> standby);

  p_standby_off_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && !(lb_n && ub_n)) |=> !standby);

  p_pd_addr_move_r9: assert property (@(posedge clk) disable iff (rst)
    (addr != $past(addr)) |=> !pwr_down);

  p_pd_unselect_r9: assert property (@(posedge clk) disable iff (rst)
    (!sel || lb_n || ub_n) |=> !pwr_down);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(pwr_down && standby));
endmodule

bind bytelane_mem_ctl bytelane_mem_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .cs         (cs),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .lb_n       (lb_n),
  .ub_n       (ub_n),
  .addr       (addr),
  .lane_drive (lane_drive),
  .lane_strobe(lane_strobe),
  .standby    (standby),
  .pwr_down   (pwr_down)
);

// File: tb/bytelane_mem_ctl_bench.sv
module bytelane_mem_ctl_bench;
  localparam int ADDR_W = 8;
  localparam int IDLE   = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, cs = 1'b0, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [1:0]  lane_drive, lane_strobe;
  logic        standby, pwr_down;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  bytelane_mem_ctl #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE)) u_bytelane_mem_ctl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs(cs), .oe_n(oe_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .lane_drive(lane_drive), .lane_strobe(lane_strobe), .standby(standby),
    .pwr_down(pwr_down)
  );

  // behavioural reference model
  logic [15:0] mm [DEPTH];
  logic [1:0]  e_drv, e_stb;
  logic [15:0] e_rd;
  logic        e_stby, e_pd;
  bit          pv;
  logic [ADDR_W-1:0] pa;
  int          run;

  always @(posedge clk) begin
    if (rst) begin
      e_drv = 2'b00; e_stb = 2'b00; e_rd = 16'h0; e_stby = 1'b1; e_pd = 1'b0;
      pv = 0; run = 0;
    end else begin
      automatic bit sel = !cs_n && cs;
      automatic logic [1:0] en = ~{ub_n, lb_n};
      automatic logic [15:0] w = mm[addr];
      automatic bit stable = sel && !lb_n && !ub_n && pv && (addr == pa);
      e_drv  = (sel && !oe_n && we_n) ? en : 2'b00;
      e_stb  = (sel && !we_n) ? en : 2'b00;
      e_rd   = {e_drv[1] ? w[15:8] : 8'h00, e_drv[0] ? w[7:0] : 8'h00};
      e_stby = !sel || (lb_n && ub_n);
      run    = stable ? run + 1 : 0;
      e_pd   = stable && (run >= IDLE);
      pv = 1; pa = addr;
      if (e_stb[0]) mm[addr][7:0]  = wr_data[7:0];
      if (e_stb[1]) mm[addr][15:8] = wr_data[15:8];
    end
  end

  task automatic expect16(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    expect16("R2", "lane_drive", 16'(lane_drive), 16'(e_drv));
    expect16("R5", "lane_strobe", 16'(lane_strobe), 16'(e_stb));
    expect16("R3", "rd_data", rd_data, e_rd);
    expect16("R7", "standby", 16'(standby), 16'(e_stby));
    expect16("R8", "pwr_down", 16'(pwr_down), 16'(e_pd));
  endtask

  // called at a falling edge; returns at the next falling edge after one rising edge
  task automatic drive(input logic cn, input logic c, input logic on, input logic wn,
                       input logic ln, input logic un, input int a, input logic [15:0] d);
    cs_n = cn; cs = c; oe_n = on; we_n = wn; lb_n = ln; ub_n = un;
    addr = a[ADDR_W-1:0]; wr_data = d;
    @(negedge clk);
    compare_model();
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 257) ^ 16'h5a3c);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R11: reset values
    for (int i = 0; i < 3; i++) drive(1, 0, 1, 1, 1, 1, 0, 16'h0);
    expect16("R11", "drive in reset", 16'(lane_drive), 16'h0);
    expect16("R11", "strobe in reset", 16'(lane_strobe), 16'h0);
    expect16("R11", "standby in reset", 16'(standby), 16'h1);
    expect16("R11", "pwr_down in reset", 16'(pwr_down), 16'h0);
    expect16("R11", "rd_data in reset", rd_data, 16'h0);
    rst = 1'b0;

    for (int a = 0; a < DEPTH; a++) drive(0, 1, 1, 0, 0, 0, a, pat(a));

    drive(0, 1, 0, 1, 0, 0, 5, 16'h0);
    expect16("R2", "full read drive", 16'(lane_drive), 16'h3);
    expect16("R3", "full read word", rd_data, pat(5));
    expect16("R7", "selected not standby", 16'(standby), 16'h0);
    drive(0, 1, 0, 1, 0, 1, 6, 16'h0);
    expect16("R3", "low lane only", rd_data, {8'h00, pat(6)[7:0]});
    drive(0, 1, 0, 1, 1, 0, 6, 16'h0);
    expect16("R3", "high lane only", rd_data, {pat(6)[15:8], 8'h00});

    drive(1, 1, 0, 1, 0, 0, 6, 16'h0);
    expect16("R1", "cs_n high no drive", 16'(lane_drive), 16'h0);
    expect16("R7", "cs_n high standby", 16'(standby), 16'h1);
    drive(0, 0, 0, 1, 0, 0, 6, 16'h0);
    expect16("R1", "cs low no drive", 16'(lane_drive), 16'h0);
    drive(1, 1, 1, 0, 0, 0, 10, 16'hffff);
    expect16("R1", "deselected write strobe", 16'(lane_strobe), 16'h0);
    drive(0, 1, 0, 1, 0, 0, 10, 16'h0);
    expect16("R1", "deselected write ignored", rd_data, pat(10));

    drive(0, 1, 0, 0, 0, 0, 7, 16'h1234);
    expect16("R4", "write beats oe", 16'(lane_drive), 16'h0);
    expect16("R5", "full write strobe", 16'(lane_strobe), 16'h3);
    drive(0, 1, 0, 1, 0, 0, 7, 16'h0);
    expect16("R12", "read after write", rd_data, 16'h1234);
    drive(0, 1, 1, 0, 0, 1, 7, 16'habcd);
    expect16("R5", "low strobe only", 16'(lane_strobe), 16'h1);
    drive(0, 1, 0, 1, 0, 0, 7, 16'h0);
    expect16("R6", "low lane write", rd_data, 16'h12cd);
    drive(0, 1, 1, 0, 1, 0, 7, 16'h9876);
    drive(0, 1, 0, 1, 0, 0, 7, 16'h0);
    expect16("R6", "high lane write", rd_data, 16'h98cd);

    drive(0, 1, 0, 1, 1, 1, 7, 16'h0);
    expect16("R7", "no lanes standby", 16'(standby), 16'h1);

    for (int i = 0; i < 5; i++) begin
      drive(0, 1, 0, 1, 0, 0, 9, 16'h0);
      expect16("R8", "pwr_down run", 16'(pwr_down), (i == 4) ? 16'h1 : 16'h0);
    end
    drive(0, 1, 0, 1, 0, 0, 8, 16'h0);
    expect16("R9", "addr move clears", 16'(pwr_down), 16'h0);
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 1, 0, 0, 8, 16'h0);
    expect16("R8", "pwr_down again", 16'(pwr_down), 16'h1);
    drive(0, 1, 0, 1, 0, 1, 8, 16'h0);
    expect16("R9", "lane off clears", 16'(pwr_down), 16'h0);
    for (int i = 0; i < 5; i++) drive(0, 1, 0, 1, 0, 0, 8, 16'h0);
    drive(0, 1, 0, 1, 1, 1, 8, 16'h0);
    expect16("R10", "standby not with pwr_down", {standby, pwr_down}, 16'h2);

    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 8) == 0, ($urandom % 8) != 0, ($urandom % 3) == 0,
            ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
            int'($urandom % 3), 16'($urandom));
      if (pwr_down && standby) expect16("R10", "both set", 16'h1, 16'h0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule